// File: doc/BRIEF.md
# Calendar Alarm and Periodic Event Flag Unit

This block sits beside a BCD calendar counter chain. It watches two event sources and turns each into a flag and an active-low output. The first source is the periodic source. It is one carry strobe picked from the counter chain, so the event interval can range from a fraction of a second up to many minutes. The second source is the alarm source. It compares a chosen, nested subset of the running time fields with a stored alarm setting, once per second tick.

Each source works in one of two modes. In interrupt mode, the output stays low while the source's flag is set, and a read of the flag clears it. In pulse mode, every event drives the output low for at most one fast-tick period. The flag stays set through reads and is cleared only by writing 0 to it. A per-source mask forces that source's output high, but the flag still records events. A third output goes low whenever either source output is low. None of the outputs depend on a chip select. The counters and the bus decode are outside this block.

Top module: `alarm_irq_unit`

## Requirements
- R1: With range code 1 and `al_sec_i == rt_sec_i`, a cycle with `tick_sec_i` high sets `flag_alm_o` at that clock edge. A seconds mismatch leaves the flag clear.
- R2: The range codes select nested fields to compare:
  - 1: seconds
  - 2: seconds and minutes
  - 3: seconds, minutes and hours
  - 4: code 3 plus day of month
  - 5: code 4 plus month
  - 6: seconds, minutes, hours and day of week

  Any field outside the selected set does not affect the match.
- R3: Range code 0, and every code from 7 to 15, produce no alarm event.
- R4: Hour fields put the PM flag in bit 6 (1 = PM) and the BCD hour in bits 5:0. With `hour24_i` high, bit 6 is left out of the compare. With `hour24_i` low, bit 6 must also match.
- R5: No alarm event occurs in a cycle where `tick_sec_i` is low.
- R6: `carry_i[carry_sel_i]` high sets `flag_per_o` at that edge. The carries that are not selected have no effect.
- R7: In interrupt mode (mode bit = 1), the output is low while the flag is set and the mask is 0. A read strobe clears the flag at that edge.
- R8: In pulse mode (mode bit = 0), a read strobe leaves the flag set. A write strobe with `wr_data_i` = 0 clears the flag in either mode. A write strobe with `wr_data_i` = 1 changes nothing.
- R9: In pulse mode, an event drives the output low from that edge until the first edge after it at which `ptick_i` is high. An event in the same cycle as `ptick_i` keeps the output low.
- R10: With the mask bit at 1, the source's output stays high while its flag still records events. Clearing the mask exposes a flag that is already set.
- R11: An event in the same cycle as a clearing read or a write of 0 leaves the flag set.
- R12: `irq_n_o` is low exactly when `per_n_o` or `alm_n_o` is low.
- R13: After reset both flags are 0 and all three outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_sec_i | input | 1 | Once-per-second strobe on which the alarm is evaluated |
| ptick_i | input | 1 | Fast tick (1/1024 s) that ends output pulses |
| carry_i | input | 8 | Carry strobes from the counter chain |
| carry_sel_i | input | 3 | Index of the carry that drives the periodic source |
| rt_sec_i | input | 7 | Running seconds, BCD |
| rt_min_i | input | 7 | Running minutes, BCD |
| rt_hour_i | input | 7 | Running hour: bit 6 PM, bits 5:0 BCD |
| rt_day_i | input | 6 | Running day of month, BCD |
| rt_mon_i | input | 5 | Running month, BCD |
| rt_wday_i | input | 3 | Running day of week, 0 to 6 |
| al_sec_i | input | 7 | Alarm seconds |
| al_min_i | input | 7 | Alarm minutes |
| al_hour_i | input | 7 | Alarm hour, same encoding as the running hour |
| al_day_i | input | 6 | Alarm day of month |
| al_mon_i | input | 5 | Alarm month |
| al_wday_i | input | 3 | Alarm day of week |
| al_range_i | input | 4 | Alarm range code |
| hour24_i | input | 1 | 1 = 24-hour compare |
| mask_per_i | input | 1 | 1 = periodic output disabled |
| mask_alm_i | input | 1 | 1 = alarm output disabled |
| irqmode_per_i | input | 1 | Periodic mode: 1 = interrupt, 0 = pulse |
| irqmode_alm_i | input | 1 | Alarm mode: 1 = interrupt, 0 = pulse |
| rd_per_i | input | 1 | Read strobe for the periodic flag |
| rd_alm_i | input | 1 | Read strobe for the alarm flag |
| wr_per_i | input | 1 | Write strobe for the periodic flag |
| wr_alm_i | input | 1 | Write strobe for the alarm flag |
| wr_data_i | input | 1 | Data bit for a flag write |
| flag_per_o | output | 1 | Periodic flag |
| flag_alm_o | output | 1 | Alarm flag |
| per_n_o | output | 1 | Periodic output, active low |
| alm_n_o | output | 1 | Alarm output, active low |
| irq_n_o | output | 1 | Combined output, active low |

## Verification
Two things can land on the same clock edge: a new event, and a host access that would clear the flag. The access is either a read in interrupt mode or a write of 0. The bench provokes this by raising a carry or a second tick together with the read or write strobe, both when the flag was clear and when it was already set. The flag and output must show the event afterwards. The same question is also asked of the pulse timer: an event in the same cycle as the fast tick must keep the pulse alive until the next fast tick.

// File: rtl/aiu_pkg.sv
package aiu_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 7;
  localparam int PM_BIT = 6;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int WDAY_W = 3;
  localparam int RNG_W  = 4;
  localparam int NSRC   = 2;
  localparam int SRC_PER = 0;
  localparam int SRC_ALM = 1;

  localparam logic [RNG_W-1:0] RNG_OFF   = 4'd0;
  localparam logic [RNG_W-1:0] RNG_S     = 4'd1;
  localparam logic [RNG_W-1:0] RNG_MS    = 4'd2;
  localparam logic [RNG_W-1:0] RNG_HMS   = 4'd3;
  localparam logic [RNG_W-1:0] RNG_DHMS  = 4'd4;
  localparam logic [RNG_W-1:0] RNG_MDHMS = 4'd5;
  localparam logic [RNG_W-1:0] RNG_WHMS  = 4'd6;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [DAY_W-1:0]  day;
    logic [MON_W-1:0]  mon;
    logic [WDAY_W-1:0] wday;
  } cal_t;
endpackage

// File: rtl/aiu_rst_sync.sv
module aiu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/aiu_alarm_cmp.sv
module aiu_alarm_cmp
  import aiu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  cal_t             rt_i,
  input  cal_t             al_i,
  input  logic [RNG_W-1:0] range_i,
  input  logic             hour24_i,
  output logic             hit_o
);
  logic eq_s, eq_m, eq_h, eq_d, eq_mo, eq_w;
  logic match;

  always_comb begin
    eq_s  = (rt_i.sec == al_i.sec);
    eq_m  = (rt_i.min == al_i.min);
    eq_d  = (rt_i.day == al_i.day);
    eq_mo = (rt_i.mon == al_i.mon);
    eq_w  = (rt_i.wday == al_i.wday);
    if (hour24_i) eq_h = (rt_i.hour[PM_BIT-1:0] == al_i.hour[PM_BIT-1:0]);
    else          eq_h = (rt_i.hour == al_i.hour);
  end

  always_comb begin
    case (range_i)
      RNG_S:     match = eq_s;
      RNG_MS:    match = eq_s & eq_m;
      RNG_HMS:   match = eq_s & eq_m & eq_h;
      RNG_DHMS:  match = eq_s & eq_m & eq_h & eq_d;
      RNG_MDHMS: match = eq_s & eq_m & eq_h & eq_d & eq_mo;
      RNG_WHMS:  match = eq_s & eq_m & eq_h & eq_w;
      default:   match = 1'b0;
    endcase
  end

  assign hit_o = tick_i & match;

  // R5
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> !hit_o);

  // R3
  range_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (range_i == RNG_OFF || range_i > RNG_WHMS) |-> !hit_o);
endmodule

// File: rtl/aiu_event_chan.sv
module aiu_event_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic mask_i,
  input  logic irq_mode_i,
  input  logic rd_i,
  input  logic wr0_i,
  input  logic ptick_i,
  output logic flag_o,
  output logic out_n_o
);
  logic flag_q, flag_d;
  logic pulse_q, pulse_d;

  always_comb begin
    flag_d = flag_q;
    if (ev_i)                     flag_d = 1'b1;
    else if (wr0_i)               flag_d = 1'b0;
    else if (rd_i && irq_mode_i)  flag_d = 1'b0;
  end

  always_comb begin
    pulse_d = pulse_q;
    if (ev_i)         pulse_d = 1'b1;
    else if (ptick_i) pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign flag_o  = flag_q;
  assign out_n_o = ~(~mask_i & (irq_mode_i ? flag_q : pulse_q));

  // R11
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i |=> flag_q);

  // R7
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode_i && rd_i && !ev_i) |=> !flag_q);

  // R8
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode_i && rd_i && !wr0_i && !ev_i && flag_q) |=> flag_q);

  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick_i && !ev_i) |=> !pulse_q);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import aiu_pkg::*;
#(
  parameter int NCARRY = 8,
  localparam int CSEL_W = $clog2(NCARRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sec_i,
  input  logic              ptick_i,
  input  logic [NCARRY-1:0] carry_i,
  input  logic [CSEL_W-1:0] carry_sel_i,
  input  logic [6:0]        rt_sec_i,
  input  logic [6:0]        rt_min_i,
  input  logic [6:0]        rt_hour_i,
  input  logic [5:0]        rt_day_i,
  input  logic [4:0]        rt_mon_i,
  input  logic [2:0]        rt_wday_i,
  input  logic [6:0]        al_sec_i,
  input  logic [6:0]        al_min_i,
  input  logic [6:0]        al_hour_i,
  input  logic [5:0]        al_day_i,
  input  logic [4:0]        al_mon_i,
  input  logic [2:0]        al_wday_i,
  input  logic [3:0]        al_range_i,
  input  logic              hour24_i,
  input  logic              mask_per_i,
  input  logic              mask_alm_i,
  input  logic              irqmode_per_i,
  input  logic              irqmode_alm_i,
  input  logic              rd_per_i,
  input  logic              rd_alm_i,
  input  logic              wr_per_i,
  input  logic              wr_alm_i,
  input  logic              wr_data_i,
  output logic              flag_per_o,
  output logic              flag_alm_o,
  output logic              per_n_o,
  output logic              alm_n_o,
  output logic              irq_n_o
);
  logic rst_sync_n;
  cal_t rt_w, al_w;
  logic alm_hit, per_ev;
  logic [NSRC-1:0] ev_v, mask_v, mode_v, rd_v, wr0_v, flag_v, outn_v;

  aiu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign rt_w = '{sec: rt_sec_i, min: rt_min_i, hour: rt_hour_i,
                  day: rt_day_i, mon: rt_mon_i, wday: rt_wday_i};
  assign al_w = '{sec: al_sec_i, min: al_min_i, hour: al_hour_i,
                  day: al_day_i, mon: al_mon_i, wday: al_wday_i};

  aiu_alarm_cmp u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_sec_i),
    .rt_i(rt_w), .al_i(al_w), .range_i(al_range_i),
    .hour24_i(hour24_i), .hit_o(alm_hit)
  );

  assign per_ev = carry_i[carry_sel_i];

  always_comb begin
    ev_v[SRC_PER]   = per_ev;
    ev_v[SRC_ALM]   = alm_hit;
    mask_v[SRC_PER] = mask_per_i;
    mask_v[SRC_ALM] = mask_alm_i;
    mode_v[SRC_PER] = irqmode_per_i;
    mode_v[SRC_ALM] = irqmode_alm_i;
    rd_v[SRC_PER]   = rd_per_i;
    rd_v[SRC_ALM]   = rd_alm_i;
    wr0_v[SRC_PER]  = wr_per_i & ~wr_data_i;
    wr0_v[SRC_ALM]  = wr_alm_i & ~wr_data_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_chan
    aiu_event_chan u_chan (
      .clk(clk), .rst_n(rst_sync_n), .ev_i(ev_v[g]), .mask_i(mask_v[g]),
      .irq_mode_i(mode_v[g]), .rd_i(rd_v[g]), .wr0_i(wr0_v[g]),
      .ptick_i(ptick_i), .flag_o(flag_v[g]), .out_n_o(outn_v[g])
    );
  end

  assign flag_per_o = flag_v[SRC_PER];
  assign flag_alm_o = flag_v[SRC_ALM];
  assign per_n_o    = outn_v[SRC_PER];
  assign alm_n_o    = outn_v[SRC_ALM];
  assign irq_n_o    = &outn_v;

  // R13
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |=> (!flag_per_o && !flag_alm_o) || rst_sync_n);
endmodule

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, ptick, hour24, mper, malm, mdper, mdalm;
  logic rdp, rda, wrp, wra, wdat;
  logic [7:0] carry;
  logic [2:0] csel;
  logic [6:0] rs, rm, rh, as_, am, ah;
  logic [5:0] rd_, ad;
  logic [4:0] rmo, amo;
  logic [2:0] rw, aw;
  logic [3:0] rng;
  logic fp, fa, pn, an, irqn;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { string r; bit fp; bit fa; bit pn; bit an; } exp_t;
  exp_t q[$];
  exp_t e;

  always #4 clk = ~clk;

  alarm_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_sec_i(tick), .ptick_i(ptick),
    .carry_i(carry), .carry_sel_i(csel),
    .rt_sec_i(rs), .rt_min_i(rm), .rt_hour_i(rh), .rt_day_i(rd_),
    .rt_mon_i(rmo), .rt_wday_i(rw),
    .al_sec_i(as_), .al_min_i(am), .al_hour_i(ah), .al_day_i(ad),
    .al_mon_i(amo), .al_wday_i(aw), .al_range_i(rng), .hour24_i(hour24),
    .mask_per_i(mper), .mask_alm_i(malm), .irqmode_per_i(mdper),
    .irqmode_alm_i(mdalm), .rd_per_i(rdp), .rd_alm_i(rda),
    .wr_per_i(wrp), .wr_alm_i(wra), .wr_data_i(wdat),
    .flag_per_o(fp), .flag_alm_o(fa), .per_n_o(pn), .alm_n_o(an),
    .irq_n_o(irqn)
  );

  task automatic chk(string r, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per pushed cycle
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.r, "flag_per", int'(fp), int'(e.fp));
      chk(e.r, "flag_alm", int'(fa), int'(e.fa));
      chk(e.r, "per_n", int'(pn), int'(e.pn));
      chk(e.r, "alm_n", int'(an), int'(e.an));
      // R12
      chk("R12", "irq_n", int'(irqn), int'(e.pn & e.an));
    end
  end

  // driver: inputs already set at a negedge; push expectation for this edge
  task automatic step(string r, bit efp, bit efa, bit epn, bit ean);
    exp_t x;
    x.r = r; x.fp = efp; x.fa = efa; x.pn = epn; x.an = ean;
    q.push_back(x);
    @(posedge clk);
    @(negedge clk);
    tick = 0; ptick = 0; carry = '0; rdp = 0; rda = 0; wrp = 0; wra = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick = 0; ptick = 0; carry = '0; csel = 3'd2; rdp = 0; rda = 0;
    wrp = 0; wra = 0; wdat = 0; hour24 = 1; mper = 0; malm = 0;
    mdper = 1; mdalm = 1; rng = 4'd1;
    rs = 7'h30; rm = 7'h15; rh = 7'h09; rd_ = 6'h12; rmo = 5'h05; rw = 3'd3;
    as_ = 7'h30; am = 7'h15; ah = 7'h09; ad = 6'h12; amo = 5'h05; aw = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    step("R13", 0, 0, 1, 1);
    // R1 seconds match, interrupt mode
    tick = 1; step("R1", 0, 1, 1, 0);
    step("R1", 0, 1, 1, 0);
    rda = 1; step("R7", 0, 0, 1, 1);
    as_ = 7'h31; tick = 1; step("R1", 0, 0, 1, 1);
    as_ = 7'h30;
    // R2 nesting
    rng = 4'd2; am = 7'h16; tick = 1; step("R2", 0, 0, 1, 1);
    am = 7'h15; ah = 7'h10; tick = 1; step("R2", 0, 1, 1, 0);
    rda = 1; step("R7", 0, 0, 1, 1);
    rng = 4'd3; tick = 1; step("R2", 0, 0, 1, 1);
    ah = 7'h09; rng = 4'd6; ad = 6'h01; amo = 5'h11; tick = 1; step("R2", 0, 1, 1, 0);
    rda = 1; step("R7", 0, 0, 1, 1);
    rng = 4'd4; tick = 1; step("R2", 0, 0, 1, 1);
    ad = 6'h12; rng = 4'd5; tick = 1; step("R2", 0, 0, 1, 1);
    amo = 5'h05; aw = 3'd5; tick = 1; step("R2", 0, 1, 1, 0);
    rda = 1; step("R7", 0, 0, 1, 1);
    aw = 3'd3;
    // R3 off codes
    rng = 4'd0; tick = 1; step("R3", 0, 0, 1, 1);
    rng = 4'd7; tick = 1; step("R3", 0, 0, 1, 1);
    rng = 4'd15; tick = 1; step("R3", 0, 0, 1, 1);
    // R5 no tick
    rng = 4'd1; step("R5", 0, 0, 1, 1);
    // R4 PM bit handling
    rng = 4'd3; ah = 7'h49; tick = 1; step("R4", 0, 1, 1, 0);
    rda = 1; step("R7", 0, 0, 1, 1);
    hour24 = 0; tick = 1; step("R4", 0, 0, 1, 1);
    rh = 7'h49; tick = 1; step("R4", 0, 1, 1, 0);
    rda = 1; step("R7", 0, 0, 1, 1);
    // R6 periodic carry select
    carry = 8'b0000_0010; step("R6", 0, 0, 1, 1);
    carry = 8'b0000_0100; step("R6", 1, 0, 0, 1);
    rdp = 1; step("R7", 0, 0, 1, 1);
    // R8 / R9 pulse mode
    mdper = 0; carry = 8'b0000_0100; step("R9", 1, 0, 0, 1);
    step("R9", 1, 0, 0, 1);
    ptick = 1; step("R9", 1, 0, 1, 1);
    rdp = 1; step("R8", 1, 0, 1, 1);
    wrp = 1; wdat = 1; step("R8", 1, 0, 1, 1);
    wrp = 1; wdat = 0; step("R8", 0, 0, 1, 1);
    carry = 8'b0000_0100; ptick = 1; step("R9", 1, 0, 0, 1);
    ptick = 1; step("R9", 1, 0, 1, 1);
    wrp = 1; step("R8", 0, 0, 1, 1);
    // R10 mask
    mdper = 1; mper = 1; carry = 8'b0000_0100; step("R10", 1, 0, 1, 1);
    mper = 0; step("R10", 1, 0, 0, 1);
    wrp = 1; step("R8", 0, 0, 1, 1);
    // R11 collisions
    carry = 8'b0000_0100; rdp = 1; step("R11", 1, 0, 0, 1);
    carry = 8'b0000_0100; rdp = 1; step("R11", 1, 0, 0, 1);
    carry = 8'b0000_0100; wrp = 1; step("R11", 1, 0, 0, 1);
    rdp = 1; step("R7", 0, 0, 1, 1);
    rng = 4'd1; tick = 1; rda = 1; step("R11", 0, 1, 1, 0);
    // R12 both active
    carry = 8'b0000_0100; step("R12", 1, 1, 0, 0);
    rda = 1; step("R7", 1, 0, 0, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule